// File: doc/BRIEF.md
# FIFO State and Transition Coverage Monitor

This block watches a FIFO from the side and never drives it. Each cycle it takes the operation that the FIFO is asked to perform and the fill level in front of that operation. It keeps an abstract model of the FIFO with six states. Two of these states describe a stalled requester: a reader that waits on an empty FIFO, and a writer that waits on a full one. Every step that falls inside the model fires one of 28 numbered transitions.

The monitor keeps a hit bit for each state and for each transition. It also reports how many distinct states and how many distinct transitions have been hit, and a saturating count of all recorded steps. An embedded functional test reads these outputs to judge how much of the FIFO's behaviour it has exercised. The ratio of distinct transitions to 28 gives the transition coverage. A synchronous clear restarts the measurement and leaves the tracked FIFO state alone.

Top module: `fifo_cov_mon`

## Requirements
- R1: After rst_ni is asserted, state_o is 0 and every hit bit and every count is 0.
- R2: The state codes are: 0 empty, 1 empty with a waiting reader, 2 empty after a non-blocking access, 3 partly filled, 4 full, 5 full with a waiting writer. The op codes are: 0 none, 1 push, 2 non-blocking push, 3 pop, 4 non-blocking pop, 5 peek, 6 non-blocking peek; code 7 is unused. From state 0 or state 2: push or non-blocking push goes to 3; pop or peek goes to 1; non-blocking pop or non-blocking peek goes to 2.
- R3: In state 1, push and non-blocking push go to state 3. Every other op leaves the state at 1.
- R4: In state 3, push or non-blocking push goes to 4 when occ_i+1 equals DEPTH. Otherwise the state stays at 3.
- R5: In state 3, pop or non-blocking pop goes to 0 when occ_i is 1 and otherwise stays at 3. Peek and non-blocking peek stay at 3.
- R6: In state 4, push goes to 5, and pop or non-blocking pop goes to 3. In state 5, only pop leaves, and it goes to 3.
- R7: An op of 0, code 7, or any (state, op) pair not listed in R2 to R6 leaves the state, every hit bit and every count unchanged.
- R8: Each recorded step sets trans_hit_o bit k. In order, k is: state 0 with push, non-blocking push, pop, peek, non-blocking pop, non-blocking peek = 0..5. State 1 with push, non-blocking push = 6, 7. State 2, in the same order as state 0 = 8..13. State 3: push to 3 = 14, push to 4 = 15, non-blocking push to 3 = 16, non-blocking push to 4 = 17, pop to 3 = 18, pop to 0 = 19, non-blocking pop to 3 = 20, non-blocking pop to 0 = 21, peek = 22, non-blocking peek = 23. State 4: pop = 24, non-blocking pop = 25, push = 26. State 5: pop = 27.
- R9: Each recorded step sets the state_hit_o bits of both its source state and its destination state. states_cov_o equals the number of set state bits.
- R10: trans_cov_o equals the number of distinct transitions hit, from 0 to 28.
- R11: total_o counts recorded steps and holds at its all-ones value instead of wrapping.
- R12: While clr_i is high, the next edge zeroes every hit bit and count. The tracked state still advances on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous clear of the coverage records |
| op_i | input | 3 | Operation requested this cycle |
| occ_i | input | OCC_W | FIFO fill level before this cycle's operation |
| state_o | output | 3 | Current abstract state |
| state_hit_o | output | 6 | State hit bitmap |
| trans_hit_o | output | 28 | Transition hit bitmap |
| states_cov_o | output | 3 | Number of distinct states hit |
| trans_cov_o | output | 5 | Number of distinct transitions hit |
| total_o | output | CNT_W | Saturating count of recorded steps |

## Verification
The bench builds the monitor with DEPTH of 4, so the full and waiting-writer states are reached after only a few pushes. It uses CNT_W of 4, so the step counter reaches all ones within one short walk, and the walk can show the counter holding at 15. The walk visits all six states and includes out-of-model and idle cycles. Directed cases then cover a clear with no operation, a clear that coincides with a state-changing push, and an asynchronous reset in the middle of a run.

// File: rtl/fifo_cov_pkg.sv
package fifo_cov_pkg;
  localparam int NUM_STATES = 6;
  localparam int NUM_TRANS  = 28;
  localparam int ST_CNT_W   = 3;
  localparam int TR_CNT_W   = 5;

  typedef enum logic [2:0] {
    ST_EMPTY      = 3'd0,
    ST_EMPTY_WAIT = 3'd1,
    ST_EMPTY_NB   = 3'd2,
    ST_PART       = 3'd3,
    ST_FULL       = 3'd4,
    ST_FULL_WAIT  = 3'd5
  } cov_state_e;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PUSH    = 3'd1,
    OP_PUSH_NB = 3'd2,
    OP_POP     = 3'd3,
    OP_POP_NB  = 3'd4,
    OP_PEEK    = 3'd5,
    OP_PEEK_NB = 3'd6,
    OP_RSVD    = 3'd7
  } fifo_op_e;

  typedef struct packed {
    logic       valid;
    cov_state_e nxt;
    logic [4:0] idx;
  } cov_step_t;

  // last_slot: this push fills the FIFO; last_item: this pop drains it
  function automatic cov_step_t cov_step(cov_state_e cur, fifo_op_e op,
                                         logic last_slot, logic last_item);
    cov_step_t s;
    logic [4:0] base;
    s.valid = 1'b0;
    s.nxt   = cur;
    s.idx   = 5'd0;
    base    = (cur == ST_EMPTY) ? 5'd0 : 5'd8;
    unique case (cur)
      ST_EMPTY, ST_EMPTY_NB: begin
        s.valid = 1'b1;
        unique case (op)
          OP_PUSH:    begin s.nxt = ST_PART;       s.idx = base;        end
          OP_PUSH_NB: begin s.nxt = ST_PART;       s.idx = base + 5'd1; end
          OP_POP:     begin s.nxt = ST_EMPTY_WAIT; s.idx = base + 5'd2; end
          OP_PEEK:    begin s.nxt = ST_EMPTY_WAIT; s.idx = base + 5'd3; end
          OP_POP_NB:  begin s.nxt = ST_EMPTY_NB;   s.idx = base + 5'd4; end
          OP_PEEK_NB: begin s.nxt = ST_EMPTY_NB;   s.idx = base + 5'd5; end
          default:    s.valid = 1'b0;
        endcase
      end
      ST_EMPTY_WAIT: begin
        s.valid = 1'b1;
        unique case (op)
          OP_PUSH:    begin s.nxt = ST_PART; s.idx = 5'd6; end
          OP_PUSH_NB: begin s.nxt = ST_PART; s.idx = 5'd7; end
          default:    s.valid = 1'b0;
        endcase
      end
      ST_PART: begin
        s.valid = 1'b1;
        unique case (op)
          OP_PUSH:    begin s.nxt = last_slot ? ST_FULL  : ST_PART; s.idx = last_slot ? 5'd15 : 5'd14; end
          OP_PUSH_NB: begin s.nxt = last_slot ? ST_FULL  : ST_PART; s.idx = last_slot ? 5'd17 : 5'd16; end
          OP_POP:     begin s.nxt = last_item ? ST_EMPTY : ST_PART; s.idx = last_item ? 5'd19 : 5'd18; end
          OP_POP_NB:  begin s.nxt = last_item ? ST_EMPTY : ST_PART; s.idx = last_item ? 5'd21 : 5'd20; end
          OP_PEEK:    s.idx = 5'd22;
          OP_PEEK_NB: s.idx = 5'd23;
          default:    s.valid = 1'b0;
        endcase
      end
      ST_FULL: begin
        s.valid = 1'b1;
        unique case (op)
          OP_POP:    begin s.nxt = ST_PART;      s.idx = 5'd24; end
          OP_POP_NB: begin s.nxt = ST_PART;      s.idx = 5'd25; end
          OP_PUSH:   begin s.nxt = ST_FULL_WAIT; s.idx = 5'd26; end
          default:   s.valid = 1'b0;
        endcase
      end
      ST_FULL_WAIT: begin
        if (op == OP_POP) begin
          s.valid = 1'b1;
          s.nxt   = ST_PART;
          s.idx   = 5'd27;
        end
      end
      default: s.valid = 1'b0;
    endcase
    if (!s.valid) s.nxt = cur;
    return s;
  endfunction
endpackage

// File: rtl/fifo_cov_track.sv
module fifo_cov_track
  import fifo_cov_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic [OCC_W-1:0] occ_i,
  output cov_state_e       state_o,
  output logic             rec_o,
  output cov_state_e       src_o,
  output cov_state_e       dst_o,
  output logic [4:0]       idx_o
);
  cov_state_e state_q;
  cov_step_t  step;
  logic       last_slot, last_item;

  assign last_slot = (int'(occ_i) + 1 == DEPTH);
  assign last_item = (int'(occ_i) == 1);
  assign step      = cov_step(state_q, fifo_op_e'(op_i), last_slot, last_item);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_EMPTY;
    else         state_q <= step.nxt;
  end

  assign state_o = state_q;
  assign rec_o   = step.valid;
  assign src_o   = state_q;
  assign dst_o   = step.nxt;
  assign idx_o   = step.idx;
endmodule

// File: rtl/fifo_cov_bitmap.sv
module fifo_cov_bitmap #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [N-1:0]  set_i,
  output logic [N-1:0]  hit_o,
  output logic [CW-1:0] cnt_o
);
  logic [N-1:0] hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hit_q <= '0;
    else if (clr_i) hit_q <= '0;
    else            hit_q <= hit_q | set_i;
  end

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CW'(hit_q[i]);
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/fifo_cov_mon.sv
module fifo_cov_mon
  import fifo_cov_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic [2:0]            op_i,
  input  logic [OCC_W-1:0]      occ_i,
  output logic [2:0]            state_o,
  output logic [NUM_STATES-1:0] state_hit_o,
  output logic [NUM_TRANS-1:0]  trans_hit_o,
  output logic [ST_CNT_W-1:0]   states_cov_o,
  output logic [TR_CNT_W-1:0]   trans_cov_o,
  output logic [CNT_W-1:0]      total_o
);
  cov_state_e            cur, src, dst;
  logic                  rec;
  logic [4:0]            idx;
  logic [NUM_STATES-1:0] st_set;
  logic [NUM_TRANS-1:0]  tr_set;
  logic [CNT_W-1:0]      total_q;

  fifo_cov_track #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_track (
    .clk_i, .rst_ni, .op_i, .occ_i,
    .state_o(cur), .rec_o(rec), .src_o(src), .dst_o(dst), .idx_o(idx)
  );

  assign st_set = rec ? ((NUM_STATES'(1) << src) | (NUM_STATES'(1) << dst)) : '0;
  assign tr_set = rec ? (NUM_TRANS'(1) << idx) : '0;

  fifo_cov_bitmap #(.N(NUM_STATES), .CW(ST_CNT_W)) u_st_map (
    .clk_i, .rst_ni, .clr_i, .set_i(st_set), .hit_o(state_hit_o), .cnt_o(states_cov_o)
  );

  fifo_cov_bitmap #(.N(NUM_TRANS), .CW(TR_CNT_W)) u_tr_map (
    .clk_i, .rst_ni, .clr_i, .set_i(tr_set), .hit_o(trans_hit_o), .cnt_o(trans_cov_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  total_q <= '0;
    else if (clr_i)               total_q <= '0;
    else if (rec && ~&total_q)    total_q <= total_q + 1'b1;
  end

  assign state_o = cur;
  assign total_o = total_q;
endmodule

// File: rtl/fifo_cov_mon_chk.sv
module fifo_cov_mon_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic [2:0]       op_i,
  input logic [2:0]       state_o,
  input logic [5:0]       state_hit_o,
  input logic [27:0]      trans_hit_o,
  input logic [4:0]       trans_cov_o,
  input logic [CNT_W-1:0] total_o
);
  a_r2_state_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd5);

  a_r3_reader_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 && op_i >= 3'd3) |=> state_o == 3'd1);

  a_r6_full_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && op_i == 3'd1) |=> state_o == 3'd5);

  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0 && !clr_i) |=> ($stable(state_o) && $stable(trans_hit_o) && $stable(total_o)));

  a_r10_cov_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> trans_cov_o >= $past(trans_cov_o));

  a_r11_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> total_o >= $past(total_o));

  a_r12_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (state_hit_o == '0 && trans_hit_o == '0 && total_o == '0));
endmodule

bind fifo_cov_mon fifo_cov_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .op_i(op_i),
  .state_o(state_o), .state_hit_o(state_hit_o), .trans_hit_o(trans_hit_o),
  .trans_cov_o(trans_cov_o), .total_o(total_o)
);

// File: tb/fifo_cov_mon_test.sv
module fifo_cov_mon_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int CNT_W = 4;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int NV = 18;
  localparam logic [4:0] NO_T = 5'd31;

  // {op, occ, expected next state, expected transition index or NO_T}
  localparam logic [13:0] VEC [NV] = '{
    {3'd6, 3'd0, 3'd2, 5'd5},
    {3'd5, 3'd0, 3'd1, 5'd11},
    {3'd3, 3'd0, 3'd1, NO_T},
    {3'd1, 3'd0, 3'd3, 5'd6},
    {3'd1, 3'd1, 3'd3, 5'd14},
    {3'd1, 3'd2, 3'd3, 5'd14},
    {3'd2, 3'd3, 3'd4, 5'd17},
    {3'd1, 3'd4, 3'd5, 5'd26},
    {3'd3, 3'd4, 3'd3, 5'd27},
    {3'd5, 3'd3, 3'd3, 5'd22},
    {3'd4, 3'd3, 3'd3, 5'd20},
    {3'd3, 3'd2, 3'd3, 5'd18},
    {3'd4, 3'd1, 3'd0, 5'd21},
    {3'd0, 3'd0, 3'd0, NO_T},
    {3'd3, 3'd0, 3'd1, 5'd2},
    {3'd2, 3'd0, 3'd3, 5'd7},
    {3'd6, 3'd1, 3'd3, 5'd23},
    {3'd3, 3'd1, 3'd0, 5'd19}
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             clr_i = 1'b0;
  logic [2:0]       op_i = 3'd0;
  logic [OCC_W-1:0] occ_i = '0;
  logic [2:0]       state_o;
  logic [5:0]       state_hit_o;
  logic [27:0]      trans_hit_o;
  logic [2:0]       states_cov_o;
  logic [4:0]       trans_cov_o;
  logic [CNT_W-1:0] total_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tags [NV] = '{"R2", "R2", "R7", "R3", "R4", "R4", "R4", "R6", "R6",
                       "R5", "R5", "R5", "R5", "R7", "R2", "R3", "R5", "R5"};

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_cov_mon #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni, .clr_i, .op_i, .occ_i, .state_o, .state_hit_o,
    .trans_hit_o, .states_cov_o, .trans_cov_o, .total_o
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(logic [2:0] op, logic [OCC_W-1:0] occ, logic clr);
    @(negedge clk);
    op_i = op; occ_i = occ; clr_i = clr;
    @(posedge clk);
    @(negedge clk);
    op_i = 3'd0; clr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [27:0]      e_tr;
    logic [5:0]       e_st;
    logic [CNT_W-1:0] e_tot;
    logic [2:0]       e_cur;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", "state", 32'(state_o), 32'd0);
    check("R1", "hits", 32'(trans_hit_o) | 32'(state_hit_o), 32'd0);
    check("R1", "total", 32'(total_o), 32'd0);
    rst_ni = 1'b1;

    e_tr = '0; e_st = '0; e_tot = '0; e_cur = 3'd0;
    for (int i = 0; i < NV; i++) begin
      logic [2:0] v_op, v_nx;
      logic [2:0] v_occ;
      logic [4:0] v_idx;
      {v_op, v_occ, v_nx, v_idx} = VEC[i];
      step(v_op, OCC_W'(v_occ), 1'b0);
      if (v_idx != NO_T) begin
        e_tr[v_idx] = 1'b1;
        e_st[e_cur] = 1'b1;
        e_st[v_nx]  = 1'b1;
        if (e_tot != '1) e_tot = e_tot + 1'b1;
      end
      e_cur = v_nx;
      check(tags[i], "state", 32'(state_o), 32'(v_nx));
      check("R8", "trans_hit", 32'(trans_hit_o), 32'(e_tr));
      check("R9", "state_hit", 32'(state_hit_o), 32'(e_st));
      check("R9", "states_cov", 32'(states_cov_o), 32'($countones(e_st)));
      check("R10", "trans_cov", 32'(trans_cov_o), 32'($countones(e_tr)));
      check("R11", "total", 32'(total_o), 32'(e_tot));
    end
    check("R9", "all states", 32'(states_cov_o), 32'd6);
    check("R10", "distinct", 32'(trans_cov_o), 32'd15);
    check("R11", "saturated", 32'(total_o), 32'd15);

    // R12 clear with no op
    step(3'd0, '0, 1'b1);
    check("R12", "trans_hit", 32'(trans_hit_o), 32'd0);
    check("R12", "state_hit", 32'(state_hit_o), 32'd0);
    check("R12", "total", 32'(total_o), 32'd0);
    check("R12", "state kept", 32'(state_o), 32'd0);

    // R12 clear together with a push from empty: state moves, records stay clear
    step(3'd1, OCC_W'(0), 1'b1);
    check("R12", "state moves", 32'(state_o), 32'd3);
    check("R12", "trans after", 32'(trans_hit_o), 32'd0);
    check("R12", "total after", 32'(total_o), 32'd0);

    // R4 fill to full, R7 peek on full ignored
    step(3'd1, OCC_W'(1), 1'b0);
    step(3'd1, OCC_W'(2), 1'b0);
    step(3'd1, OCC_W'(3), 1'b0);
    check("R4", "full", 32'(state_o), 32'd4);
    check("R8", "idx15", 32'(trans_hit_o[15]), 32'd1);
    step(3'd5, OCC_W'(4), 1'b0);
    check("R7", "peek full state", 32'(state_o), 32'd4);
    check("R7", "peek full total", 32'(total_o), 32'd3);
    step(3'd7, OCC_W'(4), 1'b0);
    check("R7", "reserved op", 32'(total_o), 32'd3);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1", "async state", 32'(state_o), 32'd0);
    check("R1", "async trans", 32'(trans_hit_o), 32'd0);
    check("R1", "async total", 32'(total_o), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    step(3'd4, OCC_W'(0), 1'b0);
    check("R2", "nb pop empty", 32'(state_o), 32'd2);
    check("R8", "idx4", 32'(trans_hit_o), 32'd16);

    finish_run();
  end
endmodule